// File: doc/BRIEF.md
# Dynamic Scan Channel Router

This block sits between a small group of tester scan channels and the compressed-scan ports of several embedded cores. On the stimulus side, each tester input channel has its own demultiplexer. The demultiplexer sends the channel's bit to one decompressor input of the core that the channel's address register selects. A channel can also broadcast its bit to the same input position on every core of a group of identical cores. On the response side, each tester output channel has its own multiplexer. It returns one compactor output of the core that its address register selects.

Configuration writes go into a pending bank of address registers. An update strobe copies the whole pending bank into the active bank in one cycle. The paths are combinational from the active bank. This means the routing changes only at pattern boundaries that the controlling logic chooses. Each input channel `ch` is wired to decompressor lane `ch mod CORE_IN_W` of every core. As a result, the lanes of one core always come from different tester channels, and the channels are spread evenly over the cores. The tester must supply at least `CORE_IN_W` input channels.

Top module: `dsr_router`

## Requirements
- R1: After reset, every active and pending address is zero, which means disabled, so every core input and every tester output reads 0 whatever the data inputs carry.
- R2: A register write changes only the pending bank. Core inputs and tester outputs keep their previous routing until an update strobe.
- R3: An update strobe sampled on a clock edge copies every pending address to the active bank on that edge. The new routing applies from then on.
- R4: Address format: bits [1:0] are the core index, bit 2 is enable and bit 3 is broadcast. An input channel `ch` with enable=1 and broadcast=0 drives core input `core*CORE_IN_W + (ch mod CORE_IN_W)` of the indexed core.
- R5: An input channel with enable=1 and broadcast=1 ignores its core index. It drives lane `ch mod CORE_IN_W` of every core whose bit is set in `BCAST_GROUP` (default cores 0 and 1) and of no other core.
- R6: A core input that no enabled channel claims is driven to 0. A core index of `NUM_CORES` or above selects no core.
- R7: When several channels claim the same core input, the lowest-numbered channel drives it.
- R8: An output channel `oc` with enable=1 and a core index below `NUM_CORES` returns compactor output `core*CORE_OUT_W + (oc mod CORE_OUT_W)`. With enable=0 or an out-of-range index it returns 0. Its broadcast bit is ignored.
- R9: Register selects 0 to NUM_IN_CH-1 address the input channels in order, and the next NUM_OUT_CH selects address the output channels. A write with any higher select changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write pending address register |
| cfg_wr_sel | input | 3 | Register select |
| cfg_wr_data | input | 4 | Address value {broadcast, enable, core[1:0]} |
| cfg_update | input | 1 | Copy pending bank to active bank |
| chan_in | input | 4 | Tester input channel bits |
| core_si | output | 6 | Decompressor inputs, core-major, lane-minor |
| core_so | input | 6 | Compactor outputs, core-major, lane-minor |
| chan_out | output | 2 | Tester output channel bits |

## Verification
The bench goes after conflicts between channels that share a lane. A design with the wrong priority would hand the core input to the higher channel. It also covers broadcast when the target core lies outside the identical group: a design that broadcasts too widely would also drive core 2. Core indices past the last core are exercised, because a design that does not range-check them would alias onto a real core or return junk. The bench also writes pending registers without an update and uses out-of-range selects. A design that routed from the pending bank, or decoded the select loosely, would change its paths at once.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  // lane of a core fed by a given tester channel (fixed wiring)
  function automatic int lane_of(input int chan, input int lanes);
    return chan % lanes;
  endfunction

  // position of (core, lane) in a core-major flat bus
  function automatic int flat_pos(input int core, input int lane, input int lanes);
    return core * lanes + lane;
  endfunction

endpackage

// File: rtl/dsr_addr_regs.sv
module dsr_addr_regs #(
  parameter int NREG = 6,
  parameter int AW   = 4,
  parameter int SELW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SELW-1:0]     wr_sel,
  input  logic [AW-1:0]       wr_data,
  input  logic                update,
  output logic [NREG*AW-1:0]  active_flat
);

  logic [NREG-1:0][AW-1:0] pending;
  logic [NREG-1:0][AW-1:0] active;
  logic                    sel_ok;

  assign sel_ok = (int'(wr_sel) < NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending[i] <= '0;
        active[i]  <= '0;
      end else begin
        if (wr_en && wr_sel == SELW'(i)) pending[i] <= wr_data;
        if (update) active[i] <= pending[i];
      end
    end
  end

  assign active_flat = active;

  // routing frozen between strobes
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(active));

  // strobe copies the whole pending bank
  assert_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> active == $past(pending));

  // out-of-range select leaves the pending bank alone
  assert_bad_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_ok) |=> $stable(pending));

endmodule

// File: rtl/dsr_in_demux.sv
module dsr_in_demux
  import dsr_pkg::*;
#(
  parameter int                   NUM_IN_CH   = 4,
  parameter int                   NUM_CORES   = 3,
  parameter int                   CORE_IN_W   = 2,
  parameter int                   CIDX_W      = 2,
  parameter int                   AW          = 4,
  parameter logic [NUM_CORES-1:0] BCAST_GROUP = '1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_IN_CH*AW-1:0]       addr,
  input  logic [NUM_IN_CH-1:0]          chan_in,
  output logic [NUM_CORES*CORE_IN_W-1:0] core_si
);

  localparam int NSI = NUM_CORES * CORE_IN_W;

  logic [NUM_IN_CH-1:0][NUM_CORES-1:0] hit;   // channel reaches core
  logic [NUM_IN_CH-1:0][NUM_CORES-1:0] win;   // channel owns its lane on core
  logic [NUM_IN_CH-1:0]                ch_en;
  logic [NUM_IN_CH-1:0]                ch_bc;
  logic [NSI-1:0]                      claimed;

  for (genvar ch = 0; ch < NUM_IN_CH; ch++) begin : g_ch
    logic [CIDX_W-1:0] idx;
    assign idx       = addr[ch*AW +: CIDX_W];
    assign ch_en[ch] = addr[ch*AW + CIDX_W];
    assign ch_bc[ch] = addr[ch*AW + CIDX_W + 1];
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign hit[ch][c] = ch_en[ch] &&
                          (ch_bc[ch] ? BCAST_GROUP[c] : (idx == CIDX_W'(c)));
    end

    // one-destination rule for unicast
    assert_unicast_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[ch] && !ch_bc[ch]) |-> ($countones(hit[ch]) <= 1));

    // broadcast never reaches a core outside the group
    assert_bcast_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[ch] && ch_bc[ch]) |-> ((hit[ch] & ~BCAST_GROUP) == '0));
  end

  // ownership: no lower channel on the same lane hits the same core
  always_comb begin
    win = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int ch = 0; ch < NUM_IN_CH; ch++) begin
        logic lower;
        lower = 1'b0;
        for (int k = 0; k < ch; k++) begin
          if (lane_of(k, CORE_IN_W) == lane_of(ch, CORE_IN_W) && hit[k][c]) lower = 1'b1;
        end
        win[ch][c] = hit[ch][c] && !lower;
      end
    end
  end

  // steering: highest channel first, so the lowest one overwrites last
  always_comb begin
    core_si = '0;
    claimed = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int l = 0; l < CORE_IN_W; l++) begin
        for (int ch = NUM_IN_CH - 1; ch >= 0; ch--) begin
          if (lane_of(ch, CORE_IN_W) == l && hit[ch][c]) begin
            core_si[flat_pos(c, l, CORE_IN_W)] = chan_in[ch];
            claimed[flat_pos(c, l, CORE_IN_W)] = 1'b1;
          end
        end
      end
    end
  end

  for (genvar i = 0; i < NSI; i++) begin : g_idle
    assert_unclaimed_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !claimed[i] |-> (core_si[i] == 1'b0));
  end

  for (genvar ch = 0; ch < NUM_IN_CH; ch++) begin : g_own
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_oc
      assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win[ch][c] |-> (core_si[c*CORE_IN_W + (ch % CORE_IN_W)] == chan_in[ch]));
    end
  end

endmodule

// File: rtl/dsr_out_mux.sv
module dsr_out_mux
  import dsr_pkg::*;
#(
  parameter int NUM_OUT_CH = 2,
  parameter int NUM_CORES  = 3,
  parameter int CORE_OUT_W = 2,
  parameter int CIDX_W     = 2,
  parameter int AW         = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_OUT_CH*AW-1:0]        addr,
  input  logic [NUM_CORES*CORE_OUT_W-1:0] core_so,
  output logic [NUM_OUT_CH-1:0]           chan_out
);

  logic [NUM_OUT_CH-1:0] sel_ok;

  for (genvar oc = 0; oc < NUM_OUT_CH; oc++) begin : g_oc
    logic [CIDX_W-1:0] idx;
    logic              en;
    logic              unused_bc;
    assign idx        = addr[oc*AW +: CIDX_W];
    assign en         = addr[oc*AW + CIDX_W];
    assign unused_bc  = addr[oc*AW + CIDX_W + 1];
    assign sel_ok[oc] = en && (int'(idx) < NUM_CORES);

    always_comb begin
      chan_out[oc] = 1'b0;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (en && idx == CIDX_W'(c))
          chan_out[oc] = core_so[flat_pos(c, lane_of(oc, CORE_OUT_W), CORE_OUT_W)];
      end
    end

    // no valid source: output held low
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok[oc] |-> (chan_out[oc] == 1'b0));

    // fixed selection and steady responses give a steady output
    assert_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(addr) && $stable(core_so)) |-> $stable(chan_out[oc]));
  end

endmodule

// File: rtl/dsr_router.sv
module dsr_router #(
  parameter int                   NUM_IN_CH   = 4,
  parameter int                   NUM_OUT_CH  = 2,
  parameter int                   NUM_CORES   = 3,
  parameter int                   CORE_IN_W   = 2,
  parameter int                   CORE_OUT_W  = 2,
  parameter logic [NUM_CORES-1:0] BCAST_GROUP = 3'b011,
  localparam int CIDX_W = (NUM_CORES > 2) ? $clog2(NUM_CORES) : 1,
  localparam int AW     = CIDX_W + 2,
  localparam int NREG   = NUM_IN_CH + NUM_OUT_CH,
  localparam int SELW   = (NREG > 2) ? $clog2(NREG) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_wr_en,
  input  logic [SELW-1:0]                 cfg_wr_sel,
  input  logic [AW-1:0]                   cfg_wr_data,
  input  logic                            cfg_update,
  input  logic [NUM_IN_CH-1:0]            chan_in,
  output logic [NUM_CORES*CORE_IN_W-1:0]  core_si,
  input  logic [NUM_CORES*CORE_OUT_W-1:0] core_so,
  output logic [NUM_OUT_CH-1:0]           chan_out
);

  logic [NREG*AW-1:0] active_flat;
  logic [NUM_IN_CH*AW-1:0]  in_addr;
  logic [NUM_OUT_CH*AW-1:0] out_addr;

  assign in_addr  = active_flat[NUM_IN_CH*AW-1:0];
  assign out_addr = active_flat[NREG*AW-1:NUM_IN_CH*AW];

  dsr_addr_regs #(.NREG(NREG), .AW(AW), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
    .wr_data(cfg_wr_data), .update(cfg_update), .active_flat(active_flat)
  );

  dsr_in_demux #(
    .NUM_IN_CH(NUM_IN_CH), .NUM_CORES(NUM_CORES), .CORE_IN_W(CORE_IN_W),
    .CIDX_W(CIDX_W), .AW(AW), .BCAST_GROUP(BCAST_GROUP)
  ) u_in (
    .clk(clk), .rst_n(rst_n), .addr(in_addr), .chan_in(chan_in), .core_si(core_si)
  );

  dsr_out_mux #(
    .NUM_OUT_CH(NUM_OUT_CH), .NUM_CORES(NUM_CORES), .CORE_OUT_W(CORE_OUT_W),
    .CIDX_W(CIDX_W), .AW(AW)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .addr(out_addr), .core_so(core_so), .chan_out(chan_out)
  );

  // reset leaves every path closed
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (core_si == '0 && chan_out == '0));

endmodule

// File: tb/tb_dsr_router.sv
`timescale 1ns/1ps
module tb_dsr_router;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [2:0] cfg_wr_sel = '0;
  logic [3:0] cfg_wr_data = '0;
  logic       cfg_update = 1'b0;
  logic [3:0] chan_in = '0;
  logic [5:0] core_si;
  logic [5:0] core_so = '0;
  logic [1:0] chan_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dsr_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .cfg_update(cfg_update), .chan_in(chan_in),
    .core_si(core_si), .core_so(core_so), .chan_out(chan_out)
  );

  // {addr[23:0] = {out1,out0,in3,in2,in1,in0}, chan_in[3:0], core_so[5:0]}
  localparam logic [33:0] VEC [8] = '{
    {24'h646544, 4'b1011, 6'b101101},
    {24'h5566CC, 4'b0110, 6'b110010},
    {24'h700575, 4'b0100, 6'b111111},
    {24'h46E6E8, 4'b0010, 6'b011000},
    {24'h000000, 4'b1111, 6'b111111},
    {24'hCD6456, 4'b1111, 6'b010110},
    {24'hCD6456, 4'b1001, 6'b101001},
    {24'h654C66, 4'b1101, 6'b001011}
  };

  // reference: scan channels upward, first one that claims a core input keeps it
  function automatic logic [5:0] ref_si(logic [23:0] a, logic [3:0] ci);
    logic [5:0] r = '0;
    for (int c = 0; c < 3; c++) begin
      for (int l = 0; l < 2; l++) begin
        bit taken = 0;
        for (int k = 0; k < 4; k++) begin
          logic [3:0] n = a[k*4 +: 4];
          bit reach = n[2] && (n[3] ? (c < 2) : (int'(n[1:0]) == c));
          if (!taken && (k % 2) == l && reach) begin
            r[c*2 + l] = ci[k];
            taken = 1;
          end
        end
      end
    end
    return r;
  endfunction

  function automatic logic [1:0] ref_out(logic [23:0] a, logic [5:0] so);
    logic [1:0] r = '0;
    for (int o = 0; o < 2; o++) begin
      logic [3:0] n = a[(4 + o)*4 +: 4];
      if (n[2] && int'(n[1:0]) < 3) r[o] = so[int'(n[1:0])*2 + (o % 2)];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic write_reg(int sel, logic [3:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 3'(sel); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    cfg_update = 1'b1;
    @(negedge clk);
    cfg_update = 1'b0;
  endtask

  task automatic load_all(logic [23:0] a);
    for (int i = 0; i < 6; i++) write_reg(i, a[i*4 +: 4]);
    strobe();
  endtask

  task automatic drive_and_check(string tag, logic [23:0] a, logic [3:0] ci, logic [5:0] so);
    @(negedge clk);
    chan_in = ci; core_so = so;
    #1;
    check({tag, " si"},  {2'b0, core_si},  {2'b0, ref_si(a, ci)});
    check({tag, " out"}, {6'b0, chan_out}, {6'b0, ref_out(a, so)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    chan_in = 4'hF; core_so = 6'h3F;
    repeat (3) @(negedge clk);
    // R1: reset state closes every path
    #1;
    check("R1 si reset",  {2'b0, core_si},  8'h00);
    check("R1 out reset", {6'b0, chan_out}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 si after release", {2'b0, core_si}, 8'h00);

    // table: unicast R4, broadcast R5, idle/out-of-range R6, priority R7, outputs R8
    for (int v = 0; v < 8; v++) begin
      logic [23:0] a = VEC[v][33:10];
      load_all(a);
      drive_and_check("R4 R5 R6 R7 R8 table", a, VEC[v][9:6], VEC[v][5:0]);
    end

    // R5: broadcast on lane 0 must not reach core 2
    load_all(24'h00000C);
    drive_and_check("R5 bcast group", 24'h00000C, 4'b0001, 6'h00);
    check("R5 core2 untouched", {7'b0, core_si[4]}, 8'h00);

    // R7: channel 0 and channel 2 both on core 1 lane 0, values differ
    load_all(24'h000505);
    drive_and_check("R7 priority a", 24'h000505, 4'b0001, 6'h00);
    drive_and_check("R7 priority b", 24'h000505, 4'b0100, 6'h00);

    // R2: writes without strobe leave routing on the active bank
    load_all(24'h646544);
    for (int i = 0; i < 6; i++) write_reg(i, 4'h0);
    drive_and_check("R2 pending only", 24'h646544, 4'b1111, 6'h3F);

    // R3: strobe applies the zeroed pending bank
    strobe();
    drive_and_check("R3 after strobe", 24'h000000, 4'b1111, 6'h3F);

    // R9: writes with select 6 and 7 change nothing, even after a strobe
    load_all(24'h646544);
    write_reg(6, 4'hF);
    write_reg(7, 4'hF);
    strobe();
    drive_and_check("R9 bad select", 24'h646544, 4'b1010, 6'h2A);

    // R6: out-of-range core index on every channel
    load_all(24'h777777);
    drive_and_check("R6 index past cores", 24'h777777, 4'b1111, 6'h3F);

    // R8: broadcast bit on output registers ignored
    load_all(24'hDC0000);
    drive_and_check("R8 out bcast ignored", 24'hDC0000, 4'b0000, 6'b001110);

    finish_run();
  end

endmodule